// File: doc/BRIEF.md
# Three-Level PWM Input Qualifier

The qualifier sits behind the analog front end of a gate-driver control input that can be driven high, driven low, or left floating at mid-rail. Four comparator flags describe where the input voltage is. The flags mark, in voltage order, the high threshold, the upper edge of the middle window, the lower edge of the middle window and the low threshold. The block turns these flags into a clean command of HIGH, LOW or TRISTATE. The power stage downstream uses that command to switch the high-side device on, switch the low-side device on, or turn both devices off.

The block remembers its current state, so the thresholds that apply depend on it. A settled HIGH drops into the window only when the input falls below the upper window edge. A settled LOW rises into the window only when the input climbs above the lower window edge. The window is left only by crossing the full high or low threshold. A mid-level input becomes a TRISTATE command only after it has stayed in the window for a hold-off time of `HOLD_CYC` consecutive clock samples. Shorter excursions leave the previous command in force. Each entry into TRISTATE from a driven level is marked by a one-cycle strobe.

Top module: `pwm3_qualifier`

## Requirements
- R1: While reset is asserted and directly after it, `cmd_o` is TRISTATE (2'b10) and `tri_enter_o` is low.
- R2: The command is encoded as LOW = 2'b00, HIGH = 2'b01 and TRISTATE = 2'b10. Each flag passes through a two-stage synchronizer. A flag change made between two edges reaches `cmd_o` after the third rising edge that follows.
- R3: From TRISTATE, or from a pending window, the command goes to HIGH only when `above_hi_i` is set and to LOW only when `below_lo_i` is set. When both flags are set, HIGH wins.
- R4: A settled HIGH stays HIGH while `above_win_i` is set. It starts a window excursion on the first sample where `above_win_i` is clear and neither `above_hi_i` nor `below_lo_i` is set.
- R5: A settled LOW stays LOW while `below_win_i` is set. It starts a window excursion on the first sample where `below_win_i` is clear and neither `above_hi_i` nor `below_lo_i` is set.
- R6: During a window excursion the previous HIGH or LOW command stays on `cmd_o`. An input that comes back only as far as the window edge does not end the excursion.
- R7: TRISTATE is declared on the `HOLD_CYC`-th consecutive window sample. Any sample outside the window restarts the count from zero.
- R8: `tri_enter_o` pulses for exactly one cycle, in the same cycle that `cmd_o` first shows TRISTATE after HIGH or LOW. It never pulses at any other time.
- R9: A settled HIGH that sees `below_lo_i` goes straight to LOW, and a settled LOW that sees `above_hi_i` goes straight to HIGH. Neither change produces a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| above_hi_i | input | 1 | Input is above the high threshold |
| above_win_i | input | 1 | Input is above the upper window edge |
| below_win_i | input | 1 | Input is below the lower window edge |
| below_lo_i | input | 1 | Input is below the low threshold |
| cmd_o | output | 2 | Qualified command: LOW, HIGH or TRISTATE |
| tri_enter_o | output | 1 | One-cycle strobe when TRISTATE is entered from a driven level |

## Verification
The bench targets the hold-off boundary in both directions. A window of `HOLD_CYC-1` samples must leave HIGH in place, and one more sample must give TRISTATE. An off-by-one counter would shed the phase one cycle early or late. The bench also holds the input at the upper window edge during an excursion: a design that let the edge flag end the excursion would return to HIGH and never reach TRISTATE. It interrupts a window with a brief high level, which catches a counter that does not restart and reaches TRISTATE too soon. Finally it applies direct high-to-low swings and contradictory flags. A design that wrongly steps through the window would pulse the strobe on these swings, and a design with the wrong flag priority would emit LOW.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'b00,
    CMD_HIGH = 2'b01,
    CMD_TRI  = 2'b10
  } cmd_e;

  typedef enum logic [2:0] {
    ST_TRI    = 3'd0,
    ST_HIGH   = 3'd1,
    ST_LOW    = 3'd2,
    ST_PEND_H = 3'd3,
    ST_PEND_L = 3'd4
  } lvl_state_e;

  localparam int unsigned NFLAG  = 4;
  localparam int unsigned F_AHI  = 3;
  localparam int unsigned F_AWIN = 2;
  localparam int unsigned F_BWIN = 1;
  localparam int unsigned F_BLO  = 0;

  function automatic cmd_e state_to_cmd(lvl_state_e s);
    case (s)
      ST_HIGH, ST_PEND_H: return CMD_HIGH;
      ST_LOW,  ST_PEND_L: return CMD_LOW;
      default:            return CMD_TRI;
    endcase
  endfunction

endpackage

// File: rtl/pwm3_sync.sv
module pwm3_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q[s] <= '0;
        end else begin
          if (s == 0) stage_q[s] <= d_i;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwm3_level_decode.sv
module pwm3_level_decode
  import pwm3_pkg::*;
(
  input  lvl_state_e       state_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic             go_high_o,
  output logic             go_low_o,
  output logic             win_o
);

  logic ahi, awin, bwin, blo;

  assign ahi  = flags_i[F_AHI];
  assign awin = flags_i[F_AWIN];
  assign bwin = flags_i[F_BWIN];
  assign blo  = flags_i[F_BLO];

  // high threshold dominates contradictory flags
  assign go_high_o = ahi;
  assign go_low_o  = blo && !ahi;

  // entry edge depends on where the input came from
  always_comb begin
    case (state_i)
      ST_HIGH: win_o = !awin && !ahi && !blo;
      ST_LOW:  win_o = !bwin && !ahi && !blo;
      default: win_o = !ahi && !blo;
    endcase
  end

endmodule

// File: rtl/pwm3_hold_timer.sv
module pwm3_hold_timer #(
  parameter int unsigned HOLD_CYC = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_i,
  output logic expire_o
);

  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!win_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // this sample is the HOLD_CYC-th consecutive window sample
  assign expire_o = win_i && (cnt_q == LAST);

  p_cnt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> cnt_q == '0);

  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/pwm3_qualifier.sv
module pwm3_qualifier
  import pwm3_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 35,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       above_hi_i,
  input  logic       above_win_i,
  input  logic       below_win_i,
  input  logic       below_lo_i,
  output logic [1:0] cmd_o,
  output logic       tri_enter_o
);

  logic [NFLAG-1:0] raw_flags, s_flags;
  logic go_high, go_low, win, expire;
  lvl_state_e state_q, state_d;
  cmd_e cmd_q;
  logic tri_q;

  assign raw_flags = {above_hi_i, above_win_i, below_win_i, below_lo_i};

  pwm3_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_flags),
    .q_o    (s_flags)
  );

  pwm3_level_decode i_decode (
    .state_i   (state_q),
    .flags_i   (s_flags),
    .go_high_o (go_high),
    .go_low_o  (go_low),
    .win_o     (win)
  );

  pwm3_hold_timer #(.HOLD_CYC(HOLD_CYC)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_i    (win),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    if (go_high)      state_d = ST_HIGH;
    else if (go_low)  state_d = ST_LOW;
    else if (win) begin
      if (expire)                 state_d = ST_TRI;
      else if (state_q == ST_HIGH) state_d = ST_PEND_H;
      else if (state_q == ST_LOW)  state_d = ST_PEND_L;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_TRI;
      cmd_q   <= CMD_TRI;
      tri_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= state_to_cmd(state_d);
      tri_q   <= (state_d == ST_TRI) && (state_q != ST_TRI);
    end
  end

  assign cmd_o       = cmd_q;
  assign tri_enter_o = tri_q;

  p_tri_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_TRI) ##1 (cmd_o == CMD_TRI) |-> tri_enter_o);

  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_enter_o |=> !tri_enter_o);

  p_strobe_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_enter_o |-> cmd_o == CMD_TRI);

  p_tri_exit_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_TRI && !s_flags[F_AHI]) |=> cmd_o != CMD_HIGH);

  p_tri_exit_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_TRI && !s_flags[F_BLO]) |=> cmd_o != CMD_LOW);

  p_keep_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_HIGH && s_flags[F_AHI]) |=> cmd_o == CMD_HIGH);

  p_keep_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_LOW && s_flags[F_BLO] && !s_flags[F_AHI]) |=> cmd_o == CMD_LOW);

  p_code_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != 2'b11);

endmodule

// File: tb/test_pwm3_qualifier.sv
module test_pwm3_qualifier;

  localparam int HOLD = 35;
  localparam logic [1:0] C_LOW = 2'b00, C_HIGH = 2'b01, C_TRI = 2'b10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] cur_flags;
  logic [1:0] cmd_o;
  logic tri_enter_o;

  int n_checks = 0;
  int n_errors = 0;
  string tag = "R1";
  bit finished = 0;

  // reference model state
  logic [1:0] m_cmd = C_TRI;
  bit m_pend = 0;
  bit m_strobe = 0;
  int m_cnt = 0;
  logic [3:0] m_s1 = '0, m_s2 = '0;

  always #2.5 clk = ~clk;

  pwm3_qualifier #(.HOLD_CYC(HOLD)) i_pwm3_qualifier (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .above_hi_i  (cur_flags[3]),
    .above_win_i (cur_flags[2]),
    .below_win_i (cur_flags[1]),
    .below_lo_i  (cur_flags[0]),
    .cmd_o       (cmd_o),
    .tri_enter_o (tri_enter_o)
  );

  // analog level 0..99: low<20, window edges 35/65, high>80
  function automatic logic [3:0] lvl(int a);
    return {a > 80, a > 65, a < 35, a < 20};
  endfunction

  function automatic void model_step(logic [3:0] f);
    bit gh, gl, w;
    gh = f[3];
    gl = f[0] && !f[3];
    if (m_cmd == C_HIGH && !m_pend)     w = !f[2] && !gh && !gl;
    else if (m_cmd == C_LOW && !m_pend) w = !f[1] && !gh && !gl;
    else                                w = !gh && !gl;
    m_strobe = 0;
    if (gh) begin m_cmd = C_HIGH; m_pend = 0; m_cnt = 0; end
    else if (gl) begin m_cmd = C_LOW; m_pend = 0; m_cnt = 0; end
    else if (w) begin
      m_cnt++;
      if (m_cnt >= HOLD) begin
        if (m_cmd != C_TRI) m_strobe = 1;
        m_cmd = C_TRI; m_pend = 0;
      end else m_pend = 1;
    end else m_cnt = 0;
  endfunction

  task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got cmd/strobe=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step(m_s2);
      m_s2 = m_s1;
      m_s1 = cur_flags;
      @(negedge clk);
      chk(tag, {cmd_o, tri_enter_o}, {m_cmd, m_strobe});
    end
  endtask

  task automatic expect_now(string req, logic [1:0] c, logic s);
    chk(req, {cmd_o, tri_enter_o}, {c, s});
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    cur_flags = lvl(50);
    repeat (3) @(negedge clk);
    expect_now("R1", C_TRI, 1'b0);
    rst_ni = 1'b1;
    tag = "R1";
    run(5);
    expect_now("R1", C_TRI, 1'b0);

    // R3: window edge alone cannot leave tristate; R2 latency of 3 edges
    tag = "R3";
    cur_flags = lvl(70); run(10);
    expect_now("R3", C_TRI, 1'b0);
    cur_flags = lvl(90); tag = "R2"; run(2);
    expect_now("R2", C_TRI, 1'b0);
    run(1);
    expect_now("R2", C_HIGH, 1'b0);

    // R4 hold at upper edge, then exact hold-off boundary
    tag = "R4";
    cur_flags = lvl(70); run(50);
    expect_now("R4", C_HIGH, 1'b0);
    cur_flags = lvl(50); tag = "R6"; run(HOLD + 1);
    expect_now("R6", C_HIGH, 1'b0);
    tag = "R7"; run(1);
    expect_now("R7", C_TRI, 1'b1);
    tag = "R8"; run(1);
    expect_now("R8", C_TRI, 1'b0);

    // R6: returning only to the window edge keeps the excursion going
    tag = "R6";
    cur_flags = lvl(90); run(5);
    cur_flags = lvl(50); run(20);
    cur_flags = lvl(70); run(HOLD - 20 + 1);
    expect_now("R6", C_HIGH, 1'b0);
    run(1);
    expect_now("R6", C_TRI, 1'b1);

    // R7: short high pulse restarts the count
    tag = "R7";
    cur_flags = lvl(90); run(5);
    cur_flags = lvl(50); run(20);
    cur_flags = lvl(90); run(3);
    cur_flags = lvl(50); run(HOLD - 5);
    expect_now("R7", C_HIGH, 1'b0);
    run(10);

    // R9 direct swing high->low, R5 lower edge
    tag = "R9";
    cur_flags = lvl(90); run(5);
    cur_flags = lvl(10); run(3);
    expect_now("R9", C_LOW, 1'b0);
    tag = "R5";
    cur_flags = lvl(30); run(50);
    expect_now("R5", C_LOW, 1'b0);
    cur_flags = lvl(50); run(HOLD + 2);
    expect_now("R5", C_TRI, 1'b1);
    tag = "R9";
    cur_flags = lvl(10); run(5);
    cur_flags = lvl(90); run(3);
    expect_now("R9", C_HIGH, 1'b0);

    // R3 priority with contradictory flags
    tag = "R3";
    cur_flags = lvl(50); run(HOLD + 5);
    cur_flags = 4'b1001; run(3);
    expect_now("R3", C_HIGH, 1'b0);

    // random segments
    tag = "R6";
    for (int k = 0; k < 400; k++) begin
      int a, len;
      a = $urandom_range(0, 99);
      len = ($urandom_range(0, 3) == 0) ? $urandom_range(HOLD - 3, HOLD + 10)
                                         : $urandom_range(1, 20);
      cur_flags = lvl(a);
      run(len);
    end
    finish_up();
  end

endmodule